// File: doc/BRIEF.md
# DMA Address Translation Walker

This block sits between a bus master that issues 32-bit DMA addresses and the memory system. When translation is on, it maps each device address in a window at the top of the 32-bit space onto a physical page through a table of 64-bit entries held in memory. For each address it works out the table slot, fetches the entry through a read port with a valid/ready handshake, checks the valid and writable bits, and returns either a 41-bit physical address or a fault code. Addresses outside the window, and every address while translation is off, are returned unchanged. Each response is a single-cycle pulse.

The window size comes from a 3-bit code in the control word. Code n gives a window of 2^(n+23) bytes that ends at address 0xFFFFFFFF, so the window runs from 8MB to 1GB. A one-entry cache keeps the last successful translation so that repeated accesses to one 8K page do not touch memory. Software can drop that entry by writing any address in its page to the flush register. Only 8K pages are handled.

Top module: `dvma_xlate`

## Requirements
- R1: Synchronous active-high reset clears the control word, the cached entry and any walk in progress. In the cycle after reset `req_ready` is 1 and `rsp_valid` and `mem_rd_valid` are 0, and a request anywhere is passed through untranslated.
- R2: While control bit 0 is clear, every request is answered in the cycle after acceptance with `rsp_bypass`=1, `rsp_paddr` equal to the zero-extended request address and `rsp_fault`=0, and no memory read is made.
- R3: With control bits 18:16 holding code n, the window is [2^32 − 2^(n+23), 2^32). A request outside the window is passed through as in R2 and does not start a walk.
- R4: A walk reads the entry at address {base[40:13], 13'b0} + 8 × ((request − window base) >> 13). Here base is the word written with `cfg_sel`=1.
- R5: An entry with bit 63 clear produces `rsp_fault`=1 (invalid).
- R6: A write request (`req_write`=1) whose entry has bit 1 clear produces `rsp_fault`=2 (protection). A read of the same entry succeeds.
- R7: On success `rsp_fault`=0, `rsp_bypass`=0 and `rsp_paddr` = {entry[40:13], request[12:0]}. Entry bits 60 and 4 have no effect on the result.
- R8: After a successful walk, a later access to the same 8K page is answered in the cycle after acceptance without a memory read. An access to a different page walks again.
- R9: A faulting walk does not update the cache, so repeating the same access walks again.
- R10: Writing an address with `cfg_sel`=2 clears the cached entry when bits 31:13 of that address match the cached page. After that, an access to the page walks again. A flush naming another page leaves the cache unchanged.
- R11: Only one walk is in flight. `req_ready` stays low from acceptance until the response. `mem_rd_valid` and `mem_rd_addr` hold steady until `mem_rd_ready`.
- R12: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 table base, 2 flush address |
| cfg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Device DMA address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Single-cycle response strobe |
| rsp_paddr | output | 41 | Physical (or passed-through) address |
| rsp_fault | output | 2 | 0 none, 1 invalid, 2 protection |
| rsp_bypass | output | 1 | Address was passed through untranslated |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 41 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_data | input | 64 | Entry contents |

## Verification
A stale or wrongly tagged cache entry shows up as a response one cycle after acceptance with no memory read and the wrong page number. The bench catches this by counting reads and latency on each request. A bad window decode appears on the first request near a window edge: the request is passed through instead of walked, or the fetch address is off by a slot. A walk state that does not clear, whether after reset or after a response, shows within a cycle as `req_ready` low or a `rsp_valid` that lasts more than one cycle.

// File: rtl/dvma_pkg.sv
package dvma_pkg;
  localparam int VA_W       = 32;
  localparam int PA_W       = 41;
  localparam int PG_SH      = 13;
  localparam int ENT_W      = 64;
  localparam int SZ_W       = 3;
  localparam int MIN_WIN_SH = 23;
  localparam int VPN_W      = VA_W - PG_SH;
  localparam int PPN_W      = PA_W - PG_SH;
  localparam int CTL_EN_BIT = 0;
  localparam int CTL_SZ_LO  = 16;
  localparam int ENT_V_BIT  = 63;
  localparam int ENT_W_BIT  = 1;

  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_INVALID = 2'd1, FLT_PROT = 2'd2} fault_e;
  typedef enum logic [1:0] {REG_CTRL = 2'd0, REG_BASE = 2'd1, REG_FLUSH = 2'd2} regsel_e;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_WAIT, ST_RESP} wstate_e;

  // lowest address of the translated window for a size code
  function automatic logic [VA_W-1:0] win_base(input logic [SZ_W-1:0] code);
    return {VA_W{1'b1}} << (int'(code) + MIN_WIN_SH);
  endfunction

  function automatic logic in_win(input logic [VA_W-1:0] a, input logic [SZ_W-1:0] code);
    return (a & win_base(code)) == win_base(code);
  endfunction

  function automatic logic [VPN_W-1:0] slot_of(input logic [VA_W-1:0] a, input logic [SZ_W-1:0] code);
    logic [VA_W-1:0] off;
    off = a - win_base(code);
    return off[VA_W-1:PG_SH];
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] base_pg,
                                                 input logic [VPN_W-1:0] slot);
    return {base_pg, {PG_SH{1'b0}}} + (PA_W'(slot) << 3);
  endfunction
endpackage

// File: rtl/dvma_win.sv
module dvma_win
  import dvma_pkg::*;
(
  input  logic             xl_en,
  input  logic [SZ_W-1:0]  size_code,
  input  logic [PPN_W-1:0] base_pg,
  input  logic [VA_W-1:0]  addr,
  output logic             walk_needed,
  output logic [PA_W-1:0]  ent_addr
);
  assign walk_needed = xl_en && in_win(addr, size_code);
  assign ent_addr    = entry_addr(base_pg, slot_of(addr, size_code));
endmodule

// File: rtl/dvma_tag_cache.sv
module dvma_tag_cache #(
  parameter int TAG_W = 19,
  parameter int DAT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  output logic [DAT_W-1:0] hit_data,
  input  logic             fill,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic [DAT_W-1:0] fill_data,
  input  logic             flush,
  input  logic [TAG_W-1:0] flush_tag,
  output logic             flush_match,
  output logic             vld
);
  logic [TAG_W-1:0] tag_q;
  logic [DAT_W-1:0] dat_q;

  assign hit         = vld && (tag_q == look_tag);
  assign hit_data    = dat_q;
  assign flush_match = flush && vld && (tag_q == flush_tag);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld   <= 1'b0;
      tag_q <= '0;
      dat_q <= '0;
    end else if (flush_match) begin
      vld <= 1'b0;
    end else if (fill) begin
      vld   <= 1'b1;
      tag_q <= fill_tag;
      dat_q <= fill_data;
    end
  end
endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [63:0]      cfg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  output logic [40:0]      rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             rsp_bypass,
  output logic             mem_rd_valid,
  input  logic             mem_rd_ready,
  output logic [40:0]      mem_rd_addr,
  input  logic             mem_rsp_valid,
  input  logic [63:0]      mem_rsp_data
);
  localparam int CDAT_W = PPN_W + 1;

  logic             xl_en;
  logic [SZ_W-1:0]  size_code;
  logic [PPN_W-1:0] base_pg;
  wstate_e          state;
  logic [VA_W-1:0]  addr_q;
  logic             write_q;
  logic [PA_W-1:0]  fetch_q;
  logic [PA_W-1:0]  paddr_q;
  fault_e           fault_q;
  logic             byp_q;

  // named internal events, observed by the checker
  logic evt_accept, evt_fill, evt_flush_hit, cache_vld;
  logic walk_needed, cache_hit;
  logic [PA_W-1:0]   ent_addr;
  logic [CDAT_W-1:0] cache_data;
  logic              ent_v, ent_w;
  logic [PPN_W-1:0]  ent_ppn;
  logic              unused_bits;

  assign unused_bits = ^{cfg_wdata[63:41], cfg_wdata[12:1], mem_rsp_data[62:41],
                         mem_rsp_data[12:2], mem_rsp_data[0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      xl_en     <= 1'b0;
      size_code <= '0;
      base_pg   <= '0;
    end else if (cfg_we) begin
      if (cfg_sel == REG_CTRL) begin
        xl_en     <= cfg_wdata[CTL_EN_BIT];
        size_code <= cfg_wdata[CTL_SZ_LO +: SZ_W];
      end
      if (cfg_sel == REG_BASE) base_pg <= cfg_wdata[PA_W-1:PG_SH];
    end
  end

  dvma_win u_win (
    .xl_en(xl_en), .size_code(size_code), .base_pg(base_pg), .addr(req_addr),
    .walk_needed(walk_needed), .ent_addr(ent_addr)
  );

  assign ent_v   = mem_rsp_data[ENT_V_BIT];
  assign ent_w   = mem_rsp_data[ENT_W_BIT];
  assign ent_ppn = mem_rsp_data[PA_W-1:PG_SH];

  assign evt_accept = req_valid && (state == ST_IDLE);
  assign evt_fill   = (state == ST_WAIT) && mem_rsp_valid && ent_v && !(write_q && !ent_w);

  dvma_tag_cache #(.TAG_W(VPN_W), .DAT_W(CDAT_W)) u_cache (
    .clk(clk), .rst(rst),
    .look_tag(req_addr[VA_W-1:PG_SH]), .hit(cache_hit), .hit_data(cache_data),
    .fill(evt_fill), .fill_tag(addr_q[VA_W-1:PG_SH]), .fill_data({ent_w, ent_ppn}),
    .flush(cfg_we && (cfg_sel == REG_FLUSH)), .flush_tag(cfg_wdata[VA_W-1:PG_SH]),
    .flush_match(evt_flush_hit), .vld(cache_vld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      fetch_q <= '0;
      paddr_q <= '0;
      fault_q <= FLT_NONE;
      byp_q   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (evt_accept) begin
          addr_q  <= req_addr;
          write_q <= req_write;
          if (!walk_needed) begin
            byp_q   <= 1'b1;
            paddr_q <= PA_W'(req_addr);
            fault_q <= FLT_NONE;
            state   <= ST_RESP;
          end else if (cache_hit) begin
            byp_q   <= 1'b0;
            paddr_q <= {cache_data[PPN_W-1:0], req_addr[PG_SH-1:0]};
            fault_q <= (req_write && !cache_data[PPN_W]) ? FLT_PROT : FLT_NONE;
            state   <= ST_RESP;
          end else begin
            fetch_q <= ent_addr;
            state   <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_rd_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          byp_q   <= 1'b0;
          paddr_q <= {ent_ppn, addr_q[PG_SH-1:0]};
          if (!ent_v)                fault_q <= FLT_INVALID;
          else if (write_q && !ent_w) fault_q <= FLT_PROT;
          else                        fault_q <= FLT_NONE;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign rsp_valid    = (state == ST_RESP);
  assign rsp_paddr    = paddr_q;
  assign rsp_fault    = fault_q;
  assign rsp_bypass   = byp_q;
  assign mem_rd_valid = (state == ST_FETCH);
  assign mem_rd_addr  = fetch_q;
endmodule

// File: rtl/dvma_xlate_chk.sv
module dvma_xlate_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_bypass,
  input logic [1:0]  rsp_fault,
  input logic [40:0] rsp_paddr,
  input logic        mem_rd_valid,
  input logic        mem_rd_ready,
  input logic [40:0] mem_rd_addr,
  input logic        evt_fill,
  input logic        evt_flush_hit,
  input logic        cache_vld,
  input logic [31:0] addr_q
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (req_ready && !rsp_valid && !mem_rd_valid)); // R1
  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_bypass) |-> (rsp_paddr == {9'b0, addr_q} && rsp_fault == 2'd0)); // R2
  AST_PAGE_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_bypass) |-> (rsp_paddr[12:0] == addr_q[12:0])); // R7
  AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
    (evt_fill && !evt_flush_hit) |=> cache_vld); // R8
  AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> !$past(evt_fill)); // R9
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
    evt_flush_hit |=> !cache_vld); // R10
  AST_READ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R11
  AST_ONE_WALK: assert property (@(posedge clk) disable iff (rst)
    mem_rd_valid |-> !req_ready); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R12
endmodule

bind dvma_xlate dvma_xlate_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_bypass(rsp_bypass), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
  .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
  .evt_fill(evt_fill), .evt_flush_hit(evt_flush_hit), .cache_vld(cache_vld), .addr_q(addr_q)
);

// File: tb/dvma_xlate_tb.sv
`timescale 1ns/1ps
module dvma_xlate_tb_top;
  localparam logic [40:0] TBASE = 41'h0_0AB0_0000;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_we = 1'b0; logic [1:0] cfg_sel = '0; logic [63:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0; logic [31:0] req_addr = '0;
  logic req_ready, rsp_valid, rsp_bypass, mem_rd_valid;
  logic [40:0] rsp_paddr, mem_rd_addr; logic [1:0] rsp_fault;
  logic mem_rd_ready = 1'b0, mem_rsp_valid = 1'b0; logic [63:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  dvma_xlate dut_i (.*);

  int nchk = 0, nfail = 0, reads = 0, stall = 0, scnt = 0;
  bit done = 1'b0;
  logic [40:0] last_fetch = '0;

  // entry contents: bits 60 and 4 set everywhere to show they are ignored
  function automatic logic [63:0] mk(input bit v, input logic [27:0] ppn, input bit w);
    return ({63'b0, v} << 63) | (64'h1 << 60) | (64'h1 << 4) | ({36'b0, ppn} << 13) | ({63'b0, w} << 1);
  endfunction
  function automatic logic [63:0] ent_of(input logic [40:0] fa);
    logic [40:0] idx = (fa - TBASE) >> 3;
    case (idx)
      41'd0: return mk(1'b1, 28'h0000111, 1'b1);
      41'd1: return mk(1'b1, 28'h0000222, 1'b0);
      41'd2: return mk(1'b0, 28'h0000333, 1'b1);
      41'd3: return mk(1'b1, 28'hFFFFFFF, 1'b1);
      default: return 64'h0;
    endcase
  endfunction

  // memory responder, acting on falling edges
  always @(negedge clk) begin
    if (rst) begin
      mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; scnt = 0;
    end else if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    else if (mem_rd_ready) begin
      mem_rd_ready = 1'b0; mem_rsp_valid = 1'b1; mem_rsp_data = ent_of(last_fetch);
    end else if (mem_rd_valid) begin
      if (scnt >= stall) begin
        mem_rd_ready = 1'b1; last_fetch = mem_rd_addr; reads++; scnt = 0;
      end else scnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [40:0] g_paddr; logic [1:0] g_fault; logic g_byp; int g_lat, g_reads; bit busy_ok, pulse_ok;

  task automatic do_req(input logic [31:0] a, input logic w);
    int r0 = reads;
    @(negedge clk); req_addr = a; req_write = w; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0; g_lat = 1; busy_ok = 1'b1;
    while (!rsp_valid && g_lat < 60) begin
      if (req_ready) busy_ok = 1'b0;
      @(negedge clk); g_lat++;
    end
    if (g_lat >= 60) chk(1'b0, "R12", "no response", 0, 1);
    g_paddr = rsp_paddr; g_fault = rsp_fault; g_byp = rsp_bypass; g_reads = reads - r0;
    @(negedge clk); pulse_ok = !rsp_valid;
  endtask

  task automatic cfg(input logic [1:0] s, input logic [63:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] addr; logic wr; logic [40:0] paddr; logic [1:0] fault;
    logic byp; logic rd; logic [40:0] fetch;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{32'h1234_5678, 1'b0, 41'h0_1234_5678,          2'd0, 1'b1, 1'b0, 41'h0},
    '{32'hFF80_0ABC, 1'b0, {28'h0000111, 13'h0ABC},  2'd0, 1'b0, 1'b1, 41'h0_0AB0_0000},
    '{32'hFF80_1F00, 1'b1, {28'h0000111, 13'h1F00},  2'd0, 1'b0, 1'b0, 41'h0},
    '{32'hFF80_2010, 1'b0, {28'h0000222, 13'h0010},  2'd0, 1'b0, 1'b1, 41'h0_0AB0_0008},
    '{32'hFF80_2010, 1'b1, 41'h0,                    2'd2, 1'b0, 1'b0, 41'h0},
    '{32'hFF80_4000, 1'b0, 41'h0,                    2'd1, 1'b0, 1'b1, 41'h0_0AB0_0010},
    '{32'hFF80_4000, 1'b0, 41'h0,                    2'd1, 1'b0, 1'b1, 41'h0_0AB0_0010},
    '{32'hFF80_6FFF, 1'b1, {28'hFFFFFFF, 13'h0FFF},  2'd0, 1'b0, 1'b1, 41'h0_0AB0_0018},
    '{32'hFF7F_FFFF, 1'b0, 41'h0_FF7F_FFFF,          2'd0, 1'b1, 1'b0, 41'h0},
    '{32'hFFFF_E123, 1'b0, 41'h0,                    2'd1, 1'b0, 1'b1, 41'h0_0AB0_1FF8}
  };

  function automatic string tag_of(input vec_t v);
    if (v.byp) return "R3";
    if (v.fault == 2'd1) return (v.addr == 32'hFF80_4000) ? "R9" : "R5";
    if (v.fault == 2'd2) return "R6";
    if (!v.rd) return "R8";
    return "R7";
  endfunction

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and control cleared
    chk(req_ready && !rsp_valid && !mem_rd_valid, "R1", "idle after reset",
        {req_ready, rsp_valid, mem_rd_valid}, 3'b100);
    do_req(32'hFF80_0000, 1'b0);
    chk(g_byp && g_reads == 0, "R1", "pass-through after reset", {g_byp, 8'(g_reads)}, {1'b1, 8'd0});

    cfg(2'd1, {23'b0, TBASE});
    cfg(2'd0, 64'h1);

    for (int i = 0; i < 10; i++) begin
      vec_t v = VECS[i];
      string t = tag_of(v);
      do_req(v.addr, v.wr);
      chk(g_byp == v.byp, t, "bypass", g_byp, v.byp);
      chk(g_fault == v.fault, t, "fault", g_fault, v.fault);
      if (v.fault == 2'd0) chk(g_paddr == v.paddr, t, "paddr", g_paddr, v.paddr);
      chk(g_reads == int'(v.rd), (v.rd ? t : "R8"), "memory reads", g_reads, v.rd);
      if (v.rd) begin
        chk(last_fetch == v.fetch, "R4", "fetch address", last_fetch, v.fetch);
        chk(busy_ok, "R11", "ready low during walk", busy_ok, 1);
      end else chk(g_lat == 1, "R8", "single-cycle answer", g_lat, 1);
      chk(pulse_ok, "R12", "response pulse", pulse_ok, 1);
    end

    // R3: largest window, code 7
    cfg(2'd0, 64'h7_0001);
    do_req(32'hC000_0010, 1'b0);
    chk(!g_byp && g_paddr == {28'h111, 13'h0010}, "R3", "window base code 7", g_paddr, {28'h111, 13'h0010});
    chk(last_fetch == TBASE, "R4", "slot 0 fetch code 7", last_fetch, TBASE);
    do_req(32'hBFFF_FFFF, 1'b0);
    chk(g_byp && g_reads == 0, "R3", "below window code 7", g_paddr, 41'h0_BFFF_FFFF);

    // R10: flush by page
    cfg(2'd2, 64'hC000_2000);
    do_req(32'hC000_1234, 1'b0);
    chk(g_reads == 0 && g_paddr == {28'h111, 13'h1234}, "R10", "other-page flush keeps entry",
        g_reads, 0);
    cfg(2'd2, 64'hC000_1FFF);
    do_req(32'hC000_0100, 1'b0);
    chk(g_reads == 1 && g_paddr == {28'h111, 13'h0100}, "R10", "same-page flush forces walk",
        g_reads, 1);

    // R11: slow memory
    stall = 4;
    do_req(32'hC000_2000, 1'b0);
    chk(busy_ok && g_paddr == {28'h222, 13'h0}, "R11", "stalled walk", g_paddr, {28'h222, 13'h0});
    stall = 0;

    // R2: translation off
    cfg(2'd0, 64'h7_0000);
    do_req(32'hC000_0010, 1'b1);
    chk(g_byp && g_reads == 0 && g_lat == 1 && g_paddr == 41'h0_C000_0010 && g_fault == 2'd0,
        "R2", "disabled pass-through", g_paddr, 41'h0_C000_0010);

    // R1: reset during a walk
    cfg(2'd0, 64'h1);
    stall = 20;
    @(negedge clk); req_addr = 32'hFF80_4000; req_write = 1'b0; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk); req_valid = 1'b0;
    @(negedge clk);
    chk(mem_rd_valid, "R11", "walk pending", mem_rd_valid, 1);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    stall = 0;
    chk(req_ready && !mem_rd_valid && !rsp_valid, "R1", "walk dropped by reset",
        {req_ready, mem_rd_valid, rsp_valid}, 3'b100);
    do_req(32'hFF80_0ABC, 1'b0);
    chk(g_byp && g_reads == 0, "R1", "control cleared by reset", g_byp, 1);

    done = 1'b1;
    summary();
  end
endmodule